// File: doc/BRIEF.md
# Dual-Slot Warp Issue Scheduler

This block picks, on every clock, up to two instructions to send to the execution pipes. The instructions come from a set of warps that stay resident on the multiprocessor. Each warp slot presents one decoded instruction: a destination register tag, two source tags and a flag that marks a memory operation. A warp becomes resident on a launch pulse and stays resident until its exit pulse. Residency is never traded for another warp, and no warp state is ever saved or restored.

Latency is hidden by moving issue between warps, not by waiting on one warp. Each warp has a scoreboard with one entry per register tag. An arithmetic result is marked busy for a fixed number of cycles after issue. A memory result stays busy until a completion pulse names that warp and tag. A warp whose instruction reads or overwrites a busy tag is skipped, and other warps issue instead. Slot 0 searches round-robin starting just past the last warp that issued. Slot 1 continues the search after slot 0's pick and never takes the same warp. So consecutive issue goes to different warps whenever another warp is eligible.

Each slot has a valid/ready handshake. An instruction counts as issued, and its warp sees an acknowledge, only when both valid and ready are high in the same cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident, and both issue slots have valid low.
- R2: A launch pulse makes a warp resident from the next cycle. The warp stays resident until its exit pulse, and the exit pulse clears its residency and every scoreboard entry of that warp from the next cycle.
- R3: A slot offers only a warp that is resident, presents a valid instruction, and has no busy tag among its two sources and its destination.
- R4: With RESULT_LAT = 12, an arithmetic instruction issued in cycle t keeps its destination busy until cycle t+12. A same-warp instruction that reads that tag is offered first in cycle t+12.
- R5: A memory-flagged instruction keeps its destination busy until a completion pulse for that warp and tag. A dependent instruction is offered in the cycle after the pulse and not during it.
- R6: When both slots are valid in one cycle, they carry different warps.
- R7: Slot 0 takes the first eligible warp at or after the round-robin pointer, counting upward with wrap. After any issue the pointer moves to one past the highest-numbered slot that fired in that cycle, so two ready warps alternate on a single slot.
- R8: Slot 1 takes the first eligible warp after slot 0's pick, counting upward with wrap.
- R9: A warp's inst_taken bit pulses, and its scoreboard changes, only when a slot holding that warp has valid and ready both high. Valid does not depend on ready.
- R10: While one warp waits on a busy tag, other eligible warps keep issuing.
- R11: An instruction whose destination tag is still busy is held, just like a read of a busy tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_launch | input | NUM_WARPS | Pulse per warp: make it resident |
| warp_exit | input | NUM_WARPS | Pulse per warp: drop residency, wipe its scoreboard |
| inst_valid | input | NUM_WARPS | Warp presents an instruction |
| inst_is_mem | input | NUM_WARPS | Instruction is a memory operation |
| inst_dst | input | NUM_WARPS*TW | Destination tag per warp, warp w in bits [w*TW +: TW] |
| inst_src_a | input | NUM_WARPS*TW | First source tag per warp |
| inst_src_b | input | NUM_WARPS*TW | Second source tag per warp |
| inst_taken | output | NUM_WARPS | Per-warp acknowledge: instruction issued this cycle |
| mem_done | input | 1 | Memory completion pulse |
| mem_done_warp | input | WW | Warp of the completing memory result |
| mem_done_tag | input | TW | Tag of the completing memory result |
| issue_valid | output | ISSUE_SLOTS | Slot holds an instruction |
| issue_ready | input | ISSUE_SLOTS | Execution side accepts the slot |
| issue_warp | output | ISSUE_SLOTS*WW | Warp of each slot |
| issue_dst | output | ISSUE_SLOTS*TW | Destination tag of each slot |
| issue_is_mem | output | ISSUE_SLOTS | Memory flag of each slot |
| resident | output | NUM_WARPS | Resident warp mask |

## Verification
The assertions assume that a completion pulse names only a warp and tag whose memory result is still pending. They also assume that a warp is never launched and exited in the same cycle. The directed stimulus sends completion only for a tag it has just issued as a memory operation. It launches and exits warps in separate cycles. It also changes a warp's instruction fields only at cycle boundaries, which keeps the offered instruction coherent with what the scoreboard checks.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // First set bit of mask at or after start (wrapping within n); -1 if none.
  function automatic int rr_first(logic [63:0] mask, int start, int n);
    int res;
    res = -1;
    for (int i = 0; i < 64; i++) begin
      if (i < n && res < 0) begin
        int idx;
        idx = start + i;
        if (idx >= n) idx = idx - n;
        if (mask[idx]) res = idx;
      end
    end
    return res;
  endfunction

  // Successor index with wrap.
  function automatic int next_slot(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Countdown preload so a dependant sees the tag free exactly lat cycles later.
  function automatic int arith_preload(int lat);
    return lat - 1;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    int r;
    r = wsched_pkg::rr_first(64'(mask), int'(start), N);
    found = (r >= 0);
    idx   = found ? IW'(r) : '0;
  end
endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
  parameter int NREG = 16,
  parameter int LAT  = 12,
  parameter int TW   = 4,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          fire,
  input  logic          fire_mem,
  input  logic [TW-1:0] dst,
  input  logic [TW-1:0] src_a,
  input  logic [TW-1:0] src_b,
  input  logic          done,
  input  logic [TW-1:0] done_tag,
  output logic          hazard
);
  localparam logic [CW-1:0] PRELOAD = CW'(wsched_pkg::arith_preload(LAT));

  logic [NREG-1:0] busy;
  logic [NREG-1:0] pend;

  for (genvar r = 0; r < NREG; r++) begin : g_tag
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
        cnt     <= '0;
        pend[r] <= 1'b0;
      end else begin
        if (fire && !fire_mem && dst == TW'(r)) cnt <= PRELOAD;
        else if (cnt != '0)                   cnt <= cnt - 1'b1;
        if (fire && fire_mem && dst == TW'(r))  pend[r] <= 1'b1;
        else if (done && done_tag == TW'(r))    pend[r] <= 1'b0;
      end
    end
    assign busy[r] = (cnt != '0) || pend[r];
  end

  assign hazard = busy[src_a] | busy[src_b] | busy[dst];

  // A firing instruction must never touch a busy tag (R4, R11)
  assert_fire_hazard_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !hazard);

  // Completion only arrives for a pending memory tag (R5)
  assert_done_matches_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wipe) |-> pend[done_tag]);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS   = 8,
  parameter int NUM_TAGS    = 16,
  parameter int RESULT_LAT  = 12,
  parameter int ISSUE_SLOTS = 2,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int TW = $clog2(NUM_TAGS),
  localparam int CW = $clog2(RESULT_LAT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WARPS-1:0]      warp_launch,
  input  logic [NUM_WARPS-1:0]      warp_exit,
  input  logic [NUM_WARPS-1:0]      inst_valid,
  input  logic [NUM_WARPS-1:0]      inst_is_mem,
  input  logic [NUM_WARPS*TW-1:0]   inst_dst,
  input  logic [NUM_WARPS*TW-1:0]   inst_src_a,
  input  logic [NUM_WARPS*TW-1:0]   inst_src_b,
  output logic [NUM_WARPS-1:0]      inst_taken,
  input  logic                      mem_done,
  input  logic [WW-1:0]             mem_done_warp,
  input  logic [TW-1:0]             mem_done_tag,
  output logic [ISSUE_SLOTS-1:0]    issue_valid,
  input  logic [ISSUE_SLOTS-1:0]    issue_ready,
  output logic [ISSUE_SLOTS*WW-1:0] issue_warp,
  output logic [ISSUE_SLOTS*TW-1:0] issue_dst,
  output logic [ISSUE_SLOTS-1:0]    issue_is_mem,
  output logic [NUM_WARPS-1:0]      resident
);
  function automatic logic [WW-1:0] next_w(logic [WW-1:0] w);
    return WW'(wsched_pkg::next_slot(int'(w), NUM_WARPS));
  endfunction

  logic [NUM_WARPS-1:0] hazard;
  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] warp_fire;
  logic [WW-1:0]        rr_ptr;

  // Per-slot selection chain
  logic [ISSUE_SLOTS-1:0] s_found;
  logic [ISSUE_SLOTS-1:0] s_fire;
  logic [WW-1:0]          s_warp  [ISSUE_SLOTS];
  logic [WW-1:0]          s_start [ISSUE_SLOTS];
  logic [NUM_WARPS-1:0]   s_mask  [ISSUE_SLOTS];

  assign eligible = resident & inst_valid & ~hazard;

  for (genvar s = 0; s < ISSUE_SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_first
      assign s_mask[s]  = eligible;
      assign s_start[s] = rr_ptr;
    end else begin : g_next
      assign s_mask[s]  = s_mask[s-1] &
                          ~(s_found[s-1] ? (NUM_WARPS'(1) << s_warp[s-1]) : '0);
      assign s_start[s] = s_found[s-1] ? next_w(s_warp[s-1]) : s_start[s-1];
    end

    rr_pick #(.N(NUM_WARPS), .IW(WW)) u_pick (
      .mask  (s_mask[s]),
      .start (s_start[s]),
      .found (s_found[s]),
      .idx   (s_warp[s])
    );

    assign s_fire[s]                   = s_found[s] & issue_ready[s];
    assign issue_valid[s]              = s_found[s];
    assign issue_warp[s*WW +: WW]      = s_warp[s];
    assign issue_dst[s*TW +: TW]       = inst_dst[s_warp[s]*TW +: TW];
    assign issue_is_mem[s]             = inst_is_mem[s_warp[s]];
  end

  // Map slot fires back onto warps
  always_comb begin
    warp_fire = '0;
    for (int s = 0; s < ISSUE_SLOTS; s++)
      if (s_fire[s]) warp_fire[s_warp[s]] = 1'b1;
  end
  assign inst_taken = warp_fire;

  // Round-robin pointer: one past the highest slot that fired
  logic          adv_en;
  logic [WW-1:0] adv_to;
  always_comb begin
    adv_en = 1'b0;
    adv_to = rr_ptr;
    for (int s = 0; s < ISSUE_SLOTS; s++)
      if (s_fire[s]) begin
        adv_en = 1'b1;
        adv_to = next_w(s_warp[s]);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rr_ptr <= '0;
    else if (adv_en) rr_ptr <= adv_to;
  end

  // Residency and per-warp scoreboards
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    always_ff @(posedge clk) begin
      if (!rst_n)              resident[w] <= 1'b0;
      else if (warp_exit[w])   resident[w] <= 1'b0;
      else if (warp_launch[w]) resident[w] <= 1'b1;
    end

    warp_scoreboard #(.NREG(NUM_TAGS), .LAT(RESULT_LAT), .TW(TW), .CW(CW)) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (warp_exit[w]),
      .fire     (warp_fire[w]),
      .fire_mem (inst_is_mem[w]),
      .dst      (inst_dst[w*TW +: TW]),
      .src_a    (inst_src_a[w*TW +: TW]),
      .src_b    (inst_src_b[w*TW +: TW]),
      .done     (mem_done && mem_done_warp == WW'(w)),
      .done_tag (mem_done_tag),
      .hazard   (hazard[w])
    );

    // Residency only moves on launch or exit (R2)
    assert_resident_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!warp_launch[w] && !warp_exit[w]) |=> $stable(resident[w]));
  end

  // Offered warps are resident (R3)
  for (genvar s = 0; s < ISSUE_SLOTS; s++) begin : g_chk
    assert_offer_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[s] |-> resident[issue_warp[s*WW +: WW]]);
    for (genvar t = s + 1; t < ISSUE_SLOTS; t++) begin : g_pair
      // Slots in one cycle carry distinct warps (R6)
      assert_slots_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid[s] && issue_valid[t]) |->
          issue_warp[s*WW +: WW] != issue_warp[t*WW +: WW]);
    end
  end

  // Acknowledges match completed handshakes one for one (R9)
  assert_taken_matches_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inst_taken) == $countones(issue_valid & issue_ready));
endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int NW = 8;
  localparam int TW = 4;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] warp_launch, warp_exit, inst_valid, inst_is_mem, inst_taken, resident;
  logic [NW*TW-1:0] inst_dst, inst_src_a, inst_src_b;
  logic          mem_done;
  logic [WW-1:0] mem_done_warp;
  logic [TW-1:0] mem_done_tag;
  logic [1:0]    issue_valid, issue_ready, issue_is_mem;
  logic [2*WW-1:0] issue_warp;
  logic [2*TW-1:0] issue_dst;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .warp_launch(warp_launch), .warp_exit(warp_exit),
    .inst_valid(inst_valid), .inst_is_mem(inst_is_mem), .inst_dst(inst_dst),
    .inst_src_a(inst_src_a), .inst_src_b(inst_src_b), .inst_taken(inst_taken),
    .mem_done(mem_done), .mem_done_warp(mem_done_warp), .mem_done_tag(mem_done_tag),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_warp(issue_warp),
    .issue_dst(issue_dst), .issue_is_mem(issue_is_mem), .resident(resident)
  );

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic put(int w, bit v, bit mem, int d, int sa, int sb);
    inst_valid[w]        = v;
    inst_is_mem[w]       = mem;
    inst_dst[w*TW +: TW]   = TW'(d);
    inst_src_a[w*TW +: TW] = TW'(sa);
    inst_src_b[w*TW +: TW] = TW'(sb);
  endtask

  function automatic int slot_warp(int s);
    return int'(issue_warp[s*WW +: WW]);
  endfunction

  task automatic idle(int n);
    inst_valid = '0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    settle();
    check(int'(resident), 0, "R1", "resident after reset");
    check(int'(issue_valid), 0, "R1", "issue_valid after reset");
  endtask

  task automatic t_launch();
    step(); warp_launch = 8'h0F;
    step(); warp_launch = '0; settle();
    check(int'(resident), 15, "R2", "resident after launch");
  endtask

  task automatic t_dual();
    step();
    for (int w = 0; w < 4; w++) put(w, 1, 0, 1, 15, 15);
    settle();
    check(int'(issue_valid), 3, "R6", "dual valid");
    check(slot_warp(0), 0, "R7", "slot0 warp first cycle");
    check(slot_warp(1), 1, "R8", "slot1 warp first cycle");
    step();
    for (int w = 0; w < 4; w++) put(w, 1, 0, 2, 15, 15);
    settle();
    check(slot_warp(0), 2, "R7", "slot0 warp second cycle");
    check(slot_warp(1), 3, "R8", "slot1 warp second cycle");
    step(); inst_valid = '0;
  endtask

  task automatic t_rotate();
    int exp_seq[3] = '{0, 1, 0};
    issue_ready = 2'b01;
    for (int k = 0; k < 3; k++) begin
      step();
      put(0, 1, 0, 3 + k, 15, 15);
      put(1, 1, 0, 3 + k, 15, 15);
      settle();
      check(slot_warp(0), exp_seq[k], "R7", "single-slot rotation");
      if (k == 0) begin
        check(int'(issue_valid[1]), 1, "R9", "slot1 valid while not ready");
        check(int'(inst_taken), 1, "R9", "only slot0 warp acknowledged");
      end
    end
    step(); inst_valid = '0; issue_ready = 2'b11;
  endtask

  task automatic t_latency();
    idle(14);
    put(2, 1, 0, 7, 15, 15); settle();
    check(slot_warp(0), 2, "R4", "producer issues");
    for (int k = 1; k <= 11; k++) begin
      step();
      put(2, 1, 0, 8, 7, 15);
      put(3, 1, 0, k, 15, 15);
      settle();
      check(int'(issue_valid), 1, "R4", "dependant held");
      check(slot_warp(0), 3, "R10", "other warp issues meanwhile");
    end
    step();
    put(3, 1, 0, 12, 15, 15); settle();
    check(int'(issue_valid), 3, "R4", "dependant released at t+12");
    check(slot_warp(0), 2, "R4", "dependant in slot0");
    step(); inst_valid = '0;
  endtask

  task automatic t_memory();
    idle(14);
    put(1, 1, 1, 5, 15, 15); settle();
    check(int'(issue_is_mem[0]), 1, "R5", "memory op offered");
    step();
    put(1, 1, 0, 6, 5, 15);
    for (int k = 0; k < 20; k++) begin
      settle();
      check(int'(issue_valid), 0, "R5", "waiting on memory");
      step();
    end
    mem_done = 1'b1; mem_done_warp = 3'd1; mem_done_tag = 4'd5; settle();
    check(int'(issue_valid), 0, "R5", "held during completion cycle");
    step(); mem_done = 1'b0; settle();
    check(int'(issue_valid), 1, "R5", "released after completion");
    check(slot_warp(0), 1, "R5", "released warp");
    step(); inst_valid = '0;
  endtask

  task automatic t_waw();
    idle(2);
    put(0, 1, 0, 9, 15, 15); settle();
    check(int'(issue_valid), 1, "R11", "first writer issues");
    for (int k = 1; k <= 11; k++) begin
      step(); put(0, 1, 0, 9, 14, 14); settle();
      check(int'(issue_valid), 0, "R11", "second writer held");
    end
    step(); settle();
    check(int'(issue_valid), 1, "R11", "second writer released");
    step(); inst_valid = '0;
  endtask

  task automatic t_exit();
    idle(2);
    put(1, 1, 0, 10, 15, 15); settle();
    check(int'(issue_valid), 1, "R2", "writer before exit");
    step(); inst_valid = '0; warp_exit[1] = 1'b1;
    step(); warp_exit = '0; put(1, 1, 0, 11, 10, 15); settle();
    check(int'(resident[1]), 0, "R2", "resident cleared by exit");
    check(int'(issue_valid), 0, "R3", "non-resident warp not offered");
    step(); warp_launch[1] = 1'b1; settle();
    check(int'(issue_valid), 0, "R3", "not offered before launch lands");
    step(); warp_launch = '0; settle();
    check(int'(resident[1]), 1, "R2", "resident after relaunch");
    check(int'(issue_valid), 1, "R2", "scoreboard wiped by exit");
    step(); inst_valid = '0;
  endtask

  task automatic t_handshake();
    idle(2);
    issue_ready = 2'b00;
    put(0, 1, 0, 11, 15, 15); settle();
    check(int'(issue_valid[0]), 1, "R9", "valid without ready");
    check(int'(inst_taken), 0, "R9", "no ack without ready");
    step(); settle();
    check(int'(issue_valid[0]), 1, "R9", "instruction not consumed");
    issue_ready = 2'b01; settle();
    check(int'(inst_taken), 1, "R9", "ack on handshake");
    step(); inst_valid = '0; issue_ready = 2'b11;
  endtask

  initial begin
    rst_n = 1'b0; warp_launch = '0; warp_exit = '0; inst_valid = '0;
    inst_is_mem = '0; inst_dst = '0; inst_src_a = '0; inst_src_b = '0;
    mem_done = 1'b0; mem_done_warp = '0; mem_done_tag = '0; issue_ready = 2'b11;
    repeat (3) step();
    rst_n = 1'b1;
    t_reset();
    t_launch();
    t_dual();
    t_rotate();
    t_latency();
    t_memory();
    t_waw();
    t_exit();
    t_handshake();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule